// File: doc/BRIEF.md
# Soft-Start Protection Restart Sequencer

This block decides what happens to the single soft-start capacitor of a resonant converter controller. The capacitor has three jobs: it ramps the error-amplifier reference at start-up, it times the grace period of an overload, and it paces the pause before a restart after a fault. The sequencer drives the current sources and the clamp on that pin through enable outputs. It watches four threshold comparators on the capacitor voltage (0.1 V, 2.4 V, 3.6 V and 4.7 V) and gates the power-stage switching.

A start-up source raises the capacitor to 2.4 V, where the clamp takes over for normal running. If the error amplifier stays saturated high, the clamp lets go and a slow source charges the capacitor. Reaching 3.6 V in that state counts as an overload shutdown. An output short or any external fault input trips the block at once. Every trip stops switching and cycles the capacitor between 4.7 V and 0.1 V a fixed number of times before a new soft start. The supply-good input arrives with its under-voltage hysteresis already applied (on at 10 V rising, off at 8.6 V falling).

All flag inputs pass through a synchroniser of `SYNC_STAGES` flip-flops. The state register follows it, so an output reacts on the `SYNC_STAGES+1`-th rising clock edge after an input changes.

Top module: `ss_restart_seq`

## Requirements
- R1: While supply-good is low, the block sits in an initial discharge state: discharge enable high, every other output low, and the restart cycle count cleared. After supply-good returns, it stays there until the capacitor is below 0.1 V.
- R2: Soft start drives start-charge enable and switch enable high until the capacitor reaches 2.4 V. The block then enters run, with clamp enable and switch enable high.
- R3: In run, a high COMP-saturated flag enters overload timing. Clamp and start-charge are off, slow-charge enable is high, and switching continues.
- R4: If the COMP-saturated flag drops during overload timing before 3.6 V, the block returns to run with the clamp enabled.
- R5: Reaching 3.6 V during overload timing moves the block to fault charge.
- R6: A short flag or any bit of the fault input during soft start, run or overload timing enters fault charge on the next state update, whatever the capacitor voltage.
- R7: Fault charge drives slow-charge enable high with switching off until the capacitor reaches 4.7 V. Fault discharge then drives discharge enable high with switching off until the capacitor is below 0.1 V.
- R8: After `RESTART_CYCLES` (default 4) complete charge and discharge pairs, the block re-enters soft start on its own. A new fault charge follows each earlier pair. Short and fault inputs have no effect during fault charge and fault discharge.
- R9: The COMP-saturated flag has no effect during soft start.
- R10: At most one of start-charge, slow-charge, discharge and clamp enables is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supply above its on threshold, hysteresis applied |
| ss_above_lo | input | 1 | Capacitor above 0.1 V |
| ss_at_ref | input | 1 | Capacitor at or above 2.4 V |
| ss_at_olp | input | 1 | Capacitor at or above 3.6 V |
| ss_at_top | input | 1 | Capacitor at or above 4.7 V |
| comp_sat | input | 1 | Error amplifier output saturated high |
| short_det | input | 1 | Reference minus feedback above 1.2 V |
| fault_in | input | NFAULT | Other protection trips, any bit set trips |
| start_chg_en | output | 1 | Start-up charge source enable |
| slow_chg_en | output | 1 | Slow (overload / restart) charge source enable |
| dis_en | output | 1 | Discharge source enable |
| clamp_en | output | 1 | 2.4 V clamp enable |
| sw_en | output | 1 | Power-stage switching enable |

## Verification
The bench builds the block with its defaults: two synchroniser stages, three fault inputs and four restart cycles. It closes the loop with a behavioural capacitor that reacts to the enables at fixed slopes per clock. With these values a complete four-pair restart, an overload that clears partway and a supply drop in the middle of a restart each fit in a few thousand cycles. The measured cycle counts between transitions can then be set against the slopes and the three-edge latency.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [2:0] {
        ST_INIT_DIS = 3'd0,
        ST_SOFT     = 3'd1,
        ST_RUN      = 3'd2,
        ST_OVLD     = 3'd3,
        ST_F_CHG    = 3'd4,
        ST_F_DIS    = 3'd5
    } ssr_state_e;

    typedef struct packed {
        logic start_chg;
        logic slow_chg;
        logic dis;
        logic clamp;
        logic sw;
    } ssr_en_t;

    typedef struct packed {
        logic good;
        logic above_lo;
        logic at_ref;
        logic at_olp;
        logic at_top;
        logic comp_sat;
        logic trip;
    } ssr_flags_t;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic [W-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= d;
            end
            assign q = s_q;
        end else begin : g_many
            logic [STAGES-1:0][W-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[STAGES-2:0], d};
            end
            assign q = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ssr_fsm.sv
module ssr_fsm
    import ssr_pkg::*;
#(
    parameter int RESTART_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ssr_flags_t flg,
    output ssr_state_e state
);
    localparam int CW = (RESTART_CYCLES < 2) ? 1 : $clog2(RESTART_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RESTART_CYCLES - 1);

    typedef struct packed {
        ssr_state_e    st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!flg.good) begin
            nxt_d.st  = ST_INIT_DIS;
            nxt_d.cnt = '0;
        end else begin
            unique case (cur_q.st)
                ST_INIT_DIS: if (!flg.above_lo) nxt_d.st = ST_SOFT;
                ST_SOFT: begin
                    if (flg.trip)        nxt_d.st = ST_F_CHG;
                    else if (flg.at_ref) nxt_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (flg.trip)          nxt_d.st = ST_F_CHG;
                    else if (flg.comp_sat) nxt_d.st = ST_OVLD;
                end
                ST_OVLD: begin
                    if (flg.trip || flg.at_olp) nxt_d.st = ST_F_CHG;
                    else if (!flg.comp_sat)     nxt_d.st = ST_RUN;
                end
                ST_F_CHG: if (flg.at_top) nxt_d.st = ST_F_DIS;
                ST_F_DIS: begin
                    if (!flg.above_lo) begin
                        if (cur_q.cnt == LAST) begin
                            nxt_d.st  = ST_SOFT;
                            nxt_d.cnt = '0;
                        end else begin
                            nxt_d.st  = ST_F_CHG;
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                end
                default: nxt_d.st = ST_INIT_DIS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= ST_INIT_DIS;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state = cur_q.st;

    a_r1_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !flg.good |=> (cur_q.st == ST_INIT_DIS && cur_q.cnt == '0));
    a_r2_ref_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.good && cur_q.st == ST_SOFT && !flg.trip && flg.at_ref) |=> cur_q.st == ST_RUN);
    a_r5_olp_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.good && cur_q.st == ST_OVLD && flg.at_olp) |=> cur_q.st == ST_F_CHG);
    a_r6_trip_now: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.good && flg.trip && (cur_q.st == ST_SOFT || cur_q.st == ST_RUN || cur_q.st == ST_OVLD))
        |=> cur_q.st == ST_F_CHG);
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LAST);
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.good && cur_q.st == ST_F_DIS && !flg.above_lo && cur_q.cnt == LAST) |=> cur_q.st == ST_SOFT);
    a_r9_sat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.good && cur_q.st == ST_SOFT && !flg.trip && !flg.at_ref) |=> cur_q.st == ST_SOFT);
endmodule

// File: rtl/ssr_outdec.sv
module ssr_outdec
    import ssr_pkg::*;
(
    input  ssr_state_e state,
    output ssr_en_t    en
);
    always_comb begin
        en = '0;
        unique case (state)
            ST_INIT_DIS: en.dis = 1'b1;
            ST_SOFT: begin
                en.start_chg = 1'b1;
                en.sw        = 1'b1;
            end
            ST_RUN: begin
                en.clamp = 1'b1;
                en.sw    = 1'b1;
            end
            ST_OVLD: begin
                en.slow_chg = 1'b1;
                en.sw       = 1'b1;
            end
            ST_F_CHG: en.slow_chg = 1'b1;
            ST_F_DIS: en.dis      = 1'b1;
            default:  en.dis      = 1'b1;
        endcase
    end
endmodule

// File: rtl/ss_restart_seq.sv
module ss_restart_seq
    import ssr_pkg::*;
#(
    parameter int NFAULT         = 3,
    parameter int SYNC_STAGES    = 2,
    parameter int RESTART_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good,
    input  logic              ss_above_lo,
    input  logic              ss_at_ref,
    input  logic              ss_at_olp,
    input  logic              ss_at_top,
    input  logic              comp_sat,
    input  logic              short_det,
    input  logic [NFAULT-1:0] fault_in,
    output logic              start_chg_en,
    output logic              slow_chg_en,
    output logic              dis_en,
    output logic              clamp_en,
    output logic              sw_en
);
    localparam int NFLAG = 7;
    localparam int SW    = NFLAG + NFAULT;

    logic [SW-1:0] raw, syn;
    ssr_flags_t    flg;
    ssr_state_e    state;
    ssr_en_t       en;

    assign raw = {supply_good, ss_above_lo, ss_at_ref, ss_at_olp, ss_at_top,
                  comp_sat, short_det, fault_in};

    ssr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign flg.good     = syn[SW-1];
    assign flg.above_lo = syn[SW-2];
    assign flg.at_ref   = syn[SW-3];
    assign flg.at_olp   = syn[SW-4];
    assign flg.at_top   = syn[SW-5];
    assign flg.comp_sat = syn[SW-6];
    assign flg.trip     = syn[SW-7] | (|syn[NFAULT-1:0]);

    ssr_fsm #(.RESTART_CYCLES(RESTART_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .flg(flg), .state(state)
    );

    ssr_outdec u_dec (.state(state), .en(en));

    assign start_chg_en = en.start_chg;
    assign slow_chg_en  = en.slow_chg;
    assign dis_en       = en.dis;
    assign clamp_en     = en.clamp;
    assign sw_en        = en.sw;

    a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_chg_en, slow_chg_en, dis_en, clamp_en}));
    a_r7_no_sw_while_dis: assert property (@(posedge clk) disable iff (!rst_n)
        dis_en |-> !sw_en);
    a_r3_sw_kept_in_ovld: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVLD) |-> (sw_en && !clamp_en));
endmodule

// File: tb/ss_restart_seq_test.sv
module ss_restart_seq_test;
    localparam int NF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_good = 1'b0, comp_sat = 1'b0, short_det = 1'b0;
    logic [NF-1:0] fault_in = '0;
    logic start_chg_en, slow_chg_en, dis_en, clamp_en, sw_en;
    int cap = 0;
    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    // Behavioural capacitor in millivolts
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clamp_en)         cap <= 2400;
        else if (start_chg_en) cap <= cap + 20;
        else if (slow_chg_en)  cap <= (cap + 10 > 5000) ? 5000 : cap + 10;
        else if (dis_en)       cap <= (cap - 30 < 0) ? 0 : cap - 30;
    end

    ss_restart_seq #(.NFAULT(NF)) uut (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
        .ss_above_lo(cap > 100), .ss_at_ref(cap >= 2400),
        .ss_at_olp(cap >= 3600), .ss_at_top(cap >= 4700),
        .comp_sat(comp_sat), .short_det(short_det), .fault_in(fault_in),
        .start_chg_en(start_chg_en), .slow_chg_en(slow_chg_en), .dis_en(dis_en),
        .clamp_en(clamp_en), .sw_en(sw_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int outs();
        return {start_chg_en, slow_chg_en, dis_en, clamp_en, sw_en};
    endfunction

    // Counts discharge phases until soft start; also checks peaks, switching, source exclusivity
    task automatic run_restart(input string req, input bool_inject, output int phases);
        int prev, sw_seen, multi, low_peak;
        phases = 0; sw_seen = 0; multi = 0; low_peak = 0; prev = dis_en;
        for (int i = 0; i < 6000 && !start_chg_en; i++) begin
            @(negedge clk);
            if (dis_en && !prev) begin
                phases++;
                if (cap < 4690) low_peak++;
                if (bool_inject && phases == 1) begin
                    short_det = 1'b1; fault_in = '1;
                end
            end
            if (bool_inject && phases == 1 && cap < 2000) begin
                short_det = 1'b0; fault_in = '0;
            end
            if (sw_en && !start_chg_en) sw_seen++;
            if ($countones({start_chg_en, slow_chg_en, dis_en, clamp_en}) > 1) multi++;
            prev = dis_en;
        end
        short_det = 1'b0; fault_in = '0;
        chk(req, "switching during restart", sw_seen, 0);
        chk("R7", "discharge began below 4.7V", low_peak, 0);
        chk("R10", "enables overlapping", multi, 0);
        chk("R8", "soft start reached", start_chg_en, 1);
    endtask

    task automatic reach_run();
        for (int i = 0; i < 6000 && !clamp_en; i++) @(negedge clk);
        step(2);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1", "outputs in reset", outs(), 5'b00100);
        rst_n = 1'b1;
        step(4);
        chk("R1", "supply low outputs", outs(), 5'b00100);
        cap = 1000;
        supply_good = 1'b1;
        step(6);
        chk("R1", "holds above 0.1V", outs(), 5'b00100);
    endtask

    task automatic t_soft();
        int n = 0;
        for (int i = 0; i < 200 && !start_chg_en; i++) @(negedge clk);
        chk("R2", "soft start outputs", outs(), 5'b10001);
        comp_sat = 1'b1;
        step(20);
        chk("R9", "sat ignored in soft start", outs(), 5'b10001);
        comp_sat = 1'b0;
        for (int i = 0; i < 400 && !clamp_en; i++) begin @(negedge clk); n++; end
        chk("R2", "run outputs", outs(), 5'b00011);
        chk_rng("R2", "soft start cycles to clamp", n + 21, 115, 135);
    endtask

    task automatic t_ovld_clear();
        comp_sat = 1'b1;
        step(5);
        chk("R3", "overload timing outputs", outs(), 5'b01001);
        step(40);
        comp_sat = 1'b0;
        step(5);
        chk("R4", "back to run", outs(), 5'b00011);
    endtask

    task automatic t_olp();
        int n = 0, ph;
        comp_sat = 1'b1;
        for (int i = 0; i < 400 && sw_en; i++) begin @(negedge clk); n++; end
        chk_rng("R5", "overload delay cycles", n, 118, 130);
        chk_rng("R5", "cap at trip", cap, 3600, 3700);
        chk("R7", "fault charge outputs", outs(), 5'b01000);
        comp_sat = 1'b0;
        run_restart("R8", 1'b1, ph);
        chk("R8", "charge/discharge pairs with ignored trips", ph, 4);
        reach_run();
    endtask

    task automatic t_short();
        int ph;
        short_det = 1'b1;
        step(2);
        short_det = 1'b0;
        step(2);
        chk("R6", "short trips at once", outs(), 5'b01000);
        chk_rng("R6", "cap at short trip", cap, 2400, 2500);
        run_restart("R7", 1'b0, ph);
        chk("R8", "pairs after short", ph, 4);
        reach_run();
    endtask

    task automatic t_fault_uvlo();
        int ph = 0, prev;
        fault_in[NF-1] = 1'b1;
        step(2);
        fault_in = '0;
        step(2);
        chk("R6", "fault input trips", outs(), 5'b01000);
        prev = dis_en;
        for (int i = 0; i < 3000 && ph < 2; i++) begin
            @(negedge clk);
            if (dis_en && !prev) ph++;
            prev = dis_en;
        end
        supply_good = 1'b0;
        step(4);
        chk("R1", "supply drop mid restart", outs(), 5'b00100);
        supply_good = 1'b1;
        for (int i = 0; i < 400 && !start_chg_en; i++) @(negedge clk);
        chk("R1", "soft start after supply return", outs(), 5'b10001);
        reach_run();
        short_det = 1'b1;
        step(2);
        short_det = 1'b0;
        run_restart("R7", 1'b0, ph);
        chk("R1", "count cleared, full pairs again", ph, 4);
    endtask

    initial begin
        t_reset();
        t_soft();
        t_ovld_clear();
        t_olp();
        t_short();
        t_fault_uvlo();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule